// File: doc/BRIEF.md
# Bounding-Box Spatial Partition Node

This block is one element of a binary tree that sorts 3-D objects by position. Each object enters on a valid/ready stream. It carries an identifier and two packed coordinate triples: the low corner and the high corner of its axis-aligned bounding box. The node reads the box on one axis, which its tree level selects, and compares that interval with a programmable split coordinate.

- An interval wholly on the low side is sent to the left child stream.
- An interval wholly on the high side is sent to the right child stream.
- An interval that crosses the split is never cut. It goes into a 16-entry keep store, which presents the retained objects on a third valid/ready stream for the node's local processing.

The node keeps a count and a union box for three groups: the left subtree, the right subtree and the retained objects. Children overwrite their own group through a report port. The node drives the sum of the three counts and the union of the three boxes toward its parent.

All three output streams follow the same back-pressure rule. A stream holds its valid and data stable until its ready is sampled high. The input is accepted only when both child slots can take a word and the keep store is not full. A stalled child or a full keep store therefore holds the producer back, and no object is dropped. Configuration is a plain write strobe. It takes effect only while no object is offered and neither child slot is occupied.

Top module: `bbox_split_node`

## Requirements
- R1: After synchronous reset, all output valids are low, `up_cnt` is 0, every axis field of `up_lo` is +32767 and every axis field of `up_hi` is -32768.
- R2: The compared axis is the configured level modulo 3. Axis 0 is X in bits [15:0], axis 1 is Y in bits [31:16] and axis 2 is Z in bits [47:32] of `in_lo`/`in_hi`. Level 5 therefore selects Z.
- R3: An object whose high coordinate on the selected axis is less than or equal to the split appears on the left stream unchanged. This includes a high coordinate exactly equal to the split.
- R4: An object that is not routed left and whose low coordinate is greater than or equal to the split appears on the right stream unchanged.
- R5: An object with low < split < high appears on the keep stream. Kept objects leave in arrival order.
- R6: While a child stream has valid high and ready low, its valid and data stay unchanged on the next cycle.
- R7: When the keep store holds 16 objects, `in_ready` is low until one leaves. No offered object is lost.
- R8: Each accepted object adds one to its group's count and widens that group's box to include the object's box, one cycle after acceptance.
- R9: A pulse on `l_upd_valid` or `r_upd_valid` replaces that subtree's count and box with the reported values. An object forwarded to the same side in the same cycle is added on top.
- R10: `up_cnt` equals the sum of the three group counts, and `up_lo`/`up_hi` equal the per-axis signed minimum and maximum over the three group boxes.
- R11: A configuration write is applied only when `in_valid` is low and neither child stream holds valid data. Otherwise the write is ignored.
- R12: All coordinate comparisons and unions are two's-complement signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_split | input | 16 | Signed split coordinate |
| cfg_level | input | 4 | Tree level; axis = level mod 3 |
| in_valid | input | 1 | Incoming object valid |
| in_ready | output | 1 | Node accepts the object |
| in_id | input | 8 | Object identifier |
| in_lo | input | 48 | Low corner, Z:Y:X |
| in_hi | input | 48 | High corner, Z:Y:X |
| l_valid | output | 1 | Left child stream valid |
| l_ready | input | 1 | Left child ready |
| l_id | output | 8 | Left object identifier |
| l_lo | output | 48 | Left object low corner |
| l_hi | output | 48 | Left object high corner |
| r_valid | output | 1 | Right child stream valid |
| r_ready | input | 1 | Right child ready |
| r_id | output | 8 | Right object identifier |
| r_lo | output | 48 | Right object low corner |
| r_hi | output | 48 | Right object high corner |
| k_valid | output | 1 | Keep stream valid |
| k_ready | input | 1 | Keep stream ready |
| k_id | output | 8 | Kept object identifier |
| k_lo | output | 48 | Kept object low corner |
| k_hi | output | 48 | Kept object high corner |
| l_upd_valid | input | 1 | Left subtree report strobe |
| l_upd_cnt | input | 16 | Left subtree reported count |
| l_upd_lo | input | 48 | Left subtree reported low corner |
| l_upd_hi | input | 48 | Left subtree reported high corner |
| r_upd_valid | input | 1 | Right subtree report strobe |
| r_upd_cnt | input | 16 | Right subtree reported count |
| r_upd_lo | input | 48 | Right subtree reported low corner |
| r_upd_hi | input | 48 | Right subtree reported high corner |
| up_cnt | output | 18 | Total object count for the parent |
| up_lo | output | 48 | Union low corner for the parent |
| up_hi | output | 48 | Union high corner for the parent |

## Verification
A wrong split, level or routing decision shows up as an object on the wrong stream. A scoreboard per stream catches it at the first handshake after the faulty acceptance, which is one cycle after the object enters. A corrupted group counter or union box shows at `up_cnt`/`up_lo`/`up_hi` in the cycle after the bad update, and stays wrong until a child report overwrites it. A keep store that loses or reorders entries is seen when the held objects drain. A fullness error shows either as a missing 17th object or as `in_ready` high while 16 objects are held.

// File: rtl/bbox_pkg.sv
package bbox_pkg;
  localparam int COORD_W = 16;
  localparam int AXES    = 3;
  localparam int ID_W    = 8;
  localparam int BOX_W   = COORD_W * AXES;

  typedef logic signed [COORD_W-1:0] coord_t;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [BOX_W-1:0] lo;
    logic [BOX_W-1:0] hi;
  } obj_t;

  typedef enum logic [1:0] {
    DST_LEFT  = 2'd0,
    DST_RIGHT = 2'd1,
    DST_KEEP  = 2'd2
  } dest_e;

  // empty-box sentinel: low corner at most positive, high corner at most negative
  localparam logic [BOX_W-1:0] EMPTY_LO_BOX = {AXES{1'b0, {(COORD_W-1){1'b1}}}};
  localparam logic [BOX_W-1:0] EMPTY_HI_BOX = {AXES{1'b1, {(COORD_W-1){1'b0}}}};

  function automatic logic [BOX_W-1:0] box_min(input logic [BOX_W-1:0] a,
                                               input logic [BOX_W-1:0] b);
    logic [BOX_W-1:0] r;
    coord_t x, y;
    for (int i = 0; i < AXES; i++) begin
      x = a[i*COORD_W +: COORD_W];
      y = b[i*COORD_W +: COORD_W];
      r[i*COORD_W +: COORD_W] = (x < y) ? x : y;
    end
    return r;
  endfunction

  function automatic logic [BOX_W-1:0] box_max(input logic [BOX_W-1:0] a,
                                               input logic [BOX_W-1:0] b);
    logic [BOX_W-1:0] r;
    coord_t x, y;
    for (int i = 0; i < AXES; i++) begin
      x = a[i*COORD_W +: COORD_W];
      y = b[i*COORD_W +: COORD_W];
      r[i*COORD_W +: COORD_W] = (x > y) ? x : y;
    end
    return r;
  endfunction
endpackage

// File: rtl/bbox_classify.sv
module bbox_classify
  import bbox_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] level,
  input  coord_t           split,
  input  logic [BOX_W-1:0] lo,
  input  logic [BOX_W-1:0] hi,
  output dest_e            dest
);
  logic [LVL_W-1:0] rem;
  coord_t           a_lo, a_hi;

  always_comb begin
    rem  = level % LVL_W'(AXES);
    a_lo = lo[COORD_W-1:0];
    a_hi = hi[COORD_W-1:0];
    for (int a = 1; a < AXES; a++) begin
      if (rem == LVL_W'(a)) begin
        a_lo = lo[a*COORD_W +: COORD_W];
        a_hi = hi[a*COORD_W +: COORD_W];
      end
    end
  end

  // touching the split on the high side still counts as the low half
  always_comb begin
    if (a_hi <= split)      dest = DST_LEFT;
    else if (a_lo >= split) dest = DST_RIGHT;
    else                    dest = DST_KEEP;
  end
endmodule

// File: rtl/bbox_out_slot.sv
module bbox_out_slot
  import bbox_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  obj_t load_obj,
  input  logic out_ready,
  output logic out_valid,
  output obj_t out_obj,
  output logic free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_obj   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_obj   <= load_obj;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bbox_keep_fifo.sv
module bbox_keep_fifo
  import bbox_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int USED_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  obj_t              push_obj,
  input  logic              pop_ready,
  output logic              out_valid,
  output obj_t              out_obj,
  output logic              full,
  output logic [USED_W-1:0] used
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  obj_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full      = (used == USED_W'(DEPTH));
  assign out_valid = (used != '0);
  assign out_obj   = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_obj;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   used <= used + USED_W'(1);
        2'b01:   used <= used - USED_W'(1);
        default: used <= used;
      endcase
    end
  end
endmodule

// File: rtl/bbox_extent_acc.sv
module bbox_extent_acc
  import bbox_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add,
  input  logic [BOX_W-1:0] add_lo,
  input  logic [BOX_W-1:0] add_hi,
  input  logic             set,
  input  logic [CNT_W-1:0] set_cnt,
  input  logic [BOX_W-1:0] set_lo,
  input  logic [BOX_W-1:0] set_hi,
  output logic [CNT_W-1:0] cnt,
  output logic [BOX_W-1:0] lo,
  output logic [BOX_W-1:0] hi
);
  logic [CNT_W-1:0] b_cnt, n_cnt;
  logic [BOX_W-1:0] b_lo, b_hi, n_lo, n_hi;

  always_comb begin
    b_cnt = set ? set_cnt : cnt;
    b_lo  = set ? set_lo  : lo;
    b_hi  = set ? set_hi  : hi;
    n_cnt = add ? b_cnt + CNT_W'(1) : b_cnt;
    n_lo  = add ? box_min(b_lo, add_lo) : b_lo;
    n_hi  = add ? box_max(b_hi, add_hi) : b_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      lo  <= EMPTY_LO_BOX;
      hi  <= EMPTY_HI_BOX;
    end else begin
      cnt <= n_cnt;
      lo  <= n_lo;
      hi  <= n_hi;
    end
  end
endmodule

// File: rtl/bbox_split_node.sv
module bbox_split_node
  import bbox_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LVL_W      = 4,
  parameter int KEEP_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [COORD_W-1:0] cfg_split,
  input  logic [LVL_W-1:0]   cfg_level,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ID_W-1:0]    in_id,
  input  logic [BOX_W-1:0]   in_lo,
  input  logic [BOX_W-1:0]   in_hi,
  output logic               l_valid,
  input  logic               l_ready,
  output logic [ID_W-1:0]    l_id,
  output logic [BOX_W-1:0]   l_lo,
  output logic [BOX_W-1:0]   l_hi,
  output logic               r_valid,
  input  logic               r_ready,
  output logic [ID_W-1:0]    r_id,
  output logic [BOX_W-1:0]   r_lo,
  output logic [BOX_W-1:0]   r_hi,
  output logic               k_valid,
  input  logic               k_ready,
  output logic [ID_W-1:0]    k_id,
  output logic [BOX_W-1:0]   k_lo,
  output logic [BOX_W-1:0]   k_hi,
  input  logic               l_upd_valid,
  input  logic [CNT_W-1:0]   l_upd_cnt,
  input  logic [BOX_W-1:0]   l_upd_lo,
  input  logic [BOX_W-1:0]   l_upd_hi,
  input  logic               r_upd_valid,
  input  logic [CNT_W-1:0]   r_upd_cnt,
  input  logic [BOX_W-1:0]   r_upd_lo,
  input  logic [BOX_W-1:0]   r_upd_hi,
  output logic [CNT_W+1:0]   up_cnt,
  output logic [BOX_W-1:0]   up_lo,
  output logic [BOX_W-1:0]   up_hi
);
  localparam int USED_W = $clog2(KEEP_DEPTH + 1);
  localparam int UP_W   = CNT_W + 2;
  localparam int NSLOT  = 2;   // 0 = left, 1 = right
  localparam int NGRP   = 3;   // 0 = left, 1 = right, 2 = kept

  coord_t           split_q;
  logic [LVL_W-1:0] level_q;
  obj_t             in_obj;
  dest_e            dest;
  logic             accept, idle, keep_full, k_push;
  logic [USED_W-1:0] keep_used;
  obj_t             keep_obj;

  logic slot_load  [NSLOT];
  logic slot_ready [NSLOT];
  logic slot_valid [NSLOT];
  logic slot_free  [NSLOT];
  obj_t slot_obj   [NSLOT];

  logic             g_add [NGRP];
  logic             g_set [NGRP];
  logic [CNT_W-1:0] g_set_cnt [NGRP];
  logic [BOX_W-1:0] g_set_lo  [NGRP];
  logic [BOX_W-1:0] g_set_hi  [NGRP];
  logic [CNT_W-1:0] g_cnt [NGRP];
  logic [BOX_W-1:0] g_lo  [NGRP];
  logic [BOX_W-1:0] g_hi  [NGRP];

  assign in_obj = '{id: in_id, lo: in_lo, hi: in_hi};

  // ---------------- configuration, applied only when quiet ----------------
  assign idle = !in_valid && !slot_valid[0] && !slot_valid[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      split_q <= '0;
      level_q <= '0;
    end else if (cfg_we && idle) begin
      split_q <= cfg_split;
      level_q <= cfg_level;
    end
  end

  // ---------------- routing decision ----------------
  bbox_classify #(.LVL_W(LVL_W)) u_cls (
    .level (level_q),
    .split (split_q),
    .lo    (in_lo),
    .hi    (in_hi),
    .dest  (dest)
  );

  assign in_ready = slot_free[0] && slot_free[1] && !keep_full;
  assign accept   = in_valid && in_ready;
  assign k_push   = accept && (dest == DST_KEEP);

  assign slot_load[0]  = accept && (dest == DST_LEFT);
  assign slot_load[1]  = accept && (dest == DST_RIGHT);
  assign slot_ready[0] = l_ready;
  assign slot_ready[1] = r_ready;

  // ---------------- child output registers ----------------
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    bbox_out_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (slot_load[s]),
      .load_obj  (in_obj),
      .out_ready (slot_ready[s]),
      .out_valid (slot_valid[s]),
      .out_obj   (slot_obj[s]),
      .free      (slot_free[s])
    );
  end

  assign l_valid = slot_valid[0];
  assign l_id    = slot_obj[0].id;
  assign l_lo    = slot_obj[0].lo;
  assign l_hi    = slot_obj[0].hi;
  assign r_valid = slot_valid[1];
  assign r_id    = slot_obj[1].id;
  assign r_lo    = slot_obj[1].lo;
  assign r_hi    = slot_obj[1].hi;

  // ---------------- keep store ----------------
  bbox_keep_fifo #(.DEPTH(KEEP_DEPTH), .USED_W(USED_W)) u_keep (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (k_push),
    .push_obj  (in_obj),
    .pop_ready (k_ready),
    .out_valid (k_valid),
    .out_obj   (keep_obj),
    .full      (keep_full),
    .used      (keep_used)
  );

  assign k_id = keep_obj.id;
  assign k_lo = keep_obj.lo;
  assign k_hi = keep_obj.hi;

  // ---------------- group bookkeeping ----------------
  always_comb begin
    g_add[0] = slot_load[0];
    g_add[1] = slot_load[1];
    g_add[2] = k_push;
    g_set[0] = l_upd_valid;
    g_set[1] = r_upd_valid;
    g_set[2] = 1'b0;
    g_set_cnt[0] = l_upd_cnt;
    g_set_cnt[1] = r_upd_cnt;
    g_set_cnt[2] = '0;
    g_set_lo[0]  = l_upd_lo;
    g_set_lo[1]  = r_upd_lo;
    g_set_lo[2]  = EMPTY_LO_BOX;
    g_set_hi[0]  = l_upd_hi;
    g_set_hi[1]  = r_upd_hi;
    g_set_hi[2]  = EMPTY_HI_BOX;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    bbox_extent_acc #(.CNT_W(CNT_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .add     (g_add[g]),
      .add_lo  (in_lo),
      .add_hi  (in_hi),
      .set     (g_set[g]),
      .set_cnt (g_set_cnt[g]),
      .set_lo  (g_set_lo[g]),
      .set_hi  (g_set_hi[g]),
      .cnt     (g_cnt[g]),
      .lo      (g_lo[g]),
      .hi      (g_hi[g])
    );
  end

  // ---------------- report to parent ----------------
  always_comb begin
    up_cnt = '0;
    up_lo  = EMPTY_LO_BOX;
    up_hi  = EMPTY_HI_BOX;
    for (int g = 0; g < NGRP; g++) begin
      up_cnt = up_cnt + UP_W'(g_cnt[g]);
      up_lo  = box_min(up_lo, g_lo[g]);
      up_hi  = box_max(up_hi, g_hi[g]);
    end
  end
endmodule

// File: rtl/bbox_split_node_chk.sv
module bbox_split_node_chk
  import bbox_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int KEEP_DEPTH = 16,
  parameter int USED_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cfg_we,
  input logic              l_valid,
  input logic              l_ready,
  input logic [ID_W-1:0]   l_id,
  input logic [BOX_W-1:0]  l_lo,
  input logic [BOX_W-1:0]  l_hi,
  input logic              r_valid,
  input logic              r_ready,
  input logic [ID_W-1:0]   r_id,
  input logic [BOX_W-1:0]  r_lo,
  input logic [BOX_W-1:0]  r_hi,
  input logic [USED_W-1:0] keep_used,
  input coord_t            split_q,
  input logic              l_upd_valid,
  input logic              r_upd_valid,
  input logic [CNT_W+1:0]  up_cnt
);
  // R6: stalled left stream holds
  p_lhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid && !l_ready) |=> (l_valid && $stable(l_id) && $stable(l_lo) && $stable(l_hi)));

  // R6: stalled right stream holds
  p_rhold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_id) && $stable(r_lo) && $stable(r_hi)));

  // R7: a full keep store refuses input
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_used == USED_W'(KEEP_DEPTH)) |-> !in_ready);

  // R11: write while busy leaves the split untouched
  p_cfg_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (in_valid || l_valid || r_valid)) |=> $stable(split_q));

  // R10: without child reports the total never shrinks
  p_up_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_upd_valid && !r_upd_valid) |=> (up_cnt >= $past(up_cnt)));
endmodule

bind bbox_split_node bbox_split_node_chk #(
  .CNT_W(CNT_W), .KEEP_DEPTH(KEEP_DEPTH), .USED_W(USED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .cfg_we(cfg_we),
  .l_valid(l_valid), .l_ready(l_ready), .l_id(l_id), .l_lo(l_lo), .l_hi(l_hi),
  .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_lo(r_lo), .r_hi(r_hi),
  .keep_used(keep_used), .split_q(split_q),
  .l_upd_valid(l_upd_valid), .r_upd_valid(r_upd_valid), .up_cnt(up_cnt)
);

// File: tb/bbox_split_node_bench.sv
`timescale 1ns/1ps
module bbox_split_node_bench;
  import bbox_pkg::*;
  localparam int CNT_W = 16;
  localparam int LVL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_split = '0;
  logic [LVL_W-1:0] cfg_level = '0;
  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_id = '0;
  logic [47:0] in_lo = '0, in_hi = '0;
  logic l_valid, r_valid, k_valid;
  logic l_ready = 1'b1, r_ready = 1'b1, k_ready = 1'b1;
  logic [7:0] l_id, r_id, k_id;
  logic [47:0] l_lo, l_hi, r_lo, r_hi, k_lo, k_hi;
  logic l_upd_valid = 1'b0, r_upd_valid = 1'b0;
  logic [CNT_W-1:0] l_upd_cnt = '0, r_upd_cnt = '0;
  logic [47:0] l_upd_lo = '0, l_upd_hi = '0, r_upd_lo = '0, r_upd_hi = '0;
  logic [CNT_W+1:0] up_cnt;
  logic [47:0] up_lo, up_hi;

  always #2.5 clk = ~clk;

  bbox_split_node u_bbox_split_node (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_split(cfg_split), .cfg_level(cfg_level),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_lo(in_lo), .in_hi(in_hi),
    .l_valid(l_valid), .l_ready(l_ready), .l_id(l_id), .l_lo(l_lo), .l_hi(l_hi),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_lo(r_lo), .r_hi(r_hi),
    .k_valid(k_valid), .k_ready(k_ready), .k_id(k_id), .k_lo(k_lo), .k_hi(k_hi),
    .l_upd_valid(l_upd_valid), .l_upd_cnt(l_upd_cnt), .l_upd_lo(l_upd_lo), .l_upd_hi(l_upd_hi),
    .r_upd_valid(r_upd_valid), .r_upd_cnt(r_upd_cnt), .r_upd_lo(r_upd_lo), .r_upd_hi(r_upd_hi),
    .up_cnt(up_cnt), .up_lo(up_lo), .up_hi(up_hi)
  );

  int checks = 0;
  int fails  = 0;
  obj_t q_l[$], q_r[$], q_k[$];

  // reference model
  int m_split = 0;
  int m_level = 0;
  int m_cnt [3];
  int m_lo [3][3];
  int m_hi [3][3];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] box3(input int x, input int y, input int z);
    return {16'(z), 16'(y), 16'(x)};
  endfunction

  function automatic int fld(input logic [47:0] b, input int a);
    logic signed [15:0] v;
    v = b[a*16 +: 16];
    return int'(v);
  endfunction

  function automatic int route(input logic [47:0] lo, input logic [47:0] hi);
    int a;
    a = m_level % 3;
    if (fld(hi, a) <= m_split) return 0;
    if (fld(lo, a) >= m_split) return 1;
    return 2;
  endfunction

  task automatic model_add(input int s, input logic [47:0] lo, input logic [47:0] hi);
    m_cnt[s]++;
    for (int a = 0; a < 3; a++) begin
      if (fld(lo, a) < m_lo[s][a]) m_lo[s][a] = fld(lo, a);
      if (fld(hi, a) > m_hi[s][a]) m_hi[s][a] = fld(hi, a);
    end
  endtask

  task automatic send(input logic [7:0] id, input logic [47:0] lo, input logic [47:0] hi);
    obj_t o;
    int d;
    o.id = id; o.lo = lo; o.hi = hi;
    @(negedge clk);
    in_id = id; in_lo = lo; in_hi = hi; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    d = route(lo, hi);
    if (d == 0) q_l.push_back(o);
    else if (d == 1) q_r.push_back(o);
    else q_k.push_back(o);
    model_add(d, lo, hi);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg(input int split, input int level, input bit applies);
    @(negedge clk);
    cfg_we = 1'b1; cfg_split = 16'(split); cfg_level = LVL_W'(level);
    @(negedge clk);
    cfg_we = 1'b0;
    if (applies) begin m_split = split; m_level = level; end
  endtask

  task automatic upd(input int side, input int cnt, input logic [47:0] lo, input logic [47:0] hi);
    @(negedge clk);
    if (side == 0) begin
      l_upd_valid = 1'b1; l_upd_cnt = CNT_W'(cnt); l_upd_lo = lo; l_upd_hi = hi;
    end else begin
      r_upd_valid = 1'b1; r_upd_cnt = CNT_W'(cnt); r_upd_lo = lo; r_upd_hi = hi;
    end
    @(negedge clk);
    l_upd_valid = 1'b0; r_upd_valid = 1'b0;
    m_cnt[side] = cnt;
    for (int a = 0; a < 3; a++) begin
      m_lo[side][a] = fld(lo, a);
      m_hi[side][a] = fld(hi, a);
    end
  endtask

  task automatic check_up(input string req);
    int c;
    int lo_a, hi_a;
    logic [47:0] elo, ehi;
    @(negedge clk); #1;
    c = m_cnt[0] + m_cnt[1] + m_cnt[2];
    for (int a = 0; a < 3; a++) begin
      lo_a = 32767; hi_a = -32768;
      for (int s = 0; s < 3; s++) begin
        if (m_lo[s][a] < lo_a) lo_a = m_lo[s][a];
        if (m_hi[s][a] > hi_a) hi_a = m_hi[s][a];
      end
      elo[a*16 +: 16] = 16'(lo_a);
      ehi[a*16 +: 16] = 16'(hi_a);
    end
    chk(up_cnt == 18'(c), req, "up_cnt", 128'(up_cnt), 128'(c));
    chk(up_lo == elo, req, "up_lo", 128'(up_lo), 128'(elo));
    chk(up_hi == ehi, req, "up_hi", 128'(up_hi), 128'(ehi));
  endtask

  task automatic wait_drain();
    int n;
    n = 0;
    @(negedge clk); #1;
    while ((q_l.size() != 0 || q_r.size() != 0 || q_k.size() != 0 || l_valid || r_valid)
           && n < 2000) begin
      @(negedge clk); #1;
      n++;
    end
  endtask

  // ---------------- scoreboard monitor ----------------
  logic p_lv = 1'b0, p_lr = 1'b0, p_rv = 1'b0, p_rr = 1'b0;
  obj_t p_lo, p_ro;

  always @(negedge clk) begin
    obj_t cur, e;
    #1;
    if (rst_n) begin
      cur = '{id: l_id, lo: l_lo, hi: l_hi};
      if (p_lv && !p_lr)   // R6
        chk(l_valid && cur == p_lo, "R6", "left hold", 128'(cur), 128'(p_lo));
      if (l_valid && l_ready) begin
        if (q_l.size() == 0) chk(1'b0, "R3", "unexpected left", 128'(cur), 128'(0));
        else begin e = q_l.pop_front(); chk(cur == e, "R3", "left object", 128'(cur), 128'(e)); end
      end
      p_lv = l_valid; p_lr = l_ready; p_lo = cur;

      cur = '{id: r_id, lo: r_lo, hi: r_hi};
      if (p_rv && !p_rr)   // R6
        chk(r_valid && cur == p_ro, "R6", "right hold", 128'(cur), 128'(p_ro));
      if (r_valid && r_ready) begin
        if (q_r.size() == 0) chk(1'b0, "R4", "unexpected right", 128'(cur), 128'(0));
        else begin e = q_r.pop_front(); chk(cur == e, "R4", "right object", 128'(cur), 128'(e)); end
      end
      p_rv = r_valid; p_rr = r_ready; p_ro = cur;

      cur = '{id: k_id, lo: k_lo, hi: k_hi};
      if (k_valid && k_ready) begin
        if (q_k.size() == 0) chk(1'b0, "R5", "unexpected keep", 128'(cur), 128'(0));
        else begin e = q_k.pop_front(); chk(cur == e, "R5", "kept object", 128'(cur), 128'(e)); end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 3; s++) begin
      m_cnt[s] = 0;
      for (int a = 0; a < 3; a++) begin m_lo[s][a] = 32767; m_hi[s][a] = -32768; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!l_valid && !r_valid && !k_valid, "R1", "valids", 128'({l_valid, r_valid, k_valid}), 128'(0));
    chk(up_cnt == '0, "R1", "up_cnt", 128'(up_cnt), 128'(0));
    chk(up_lo == box3(32767, 32767, 32767), "R1", "up_lo", 128'(up_lo), 128'(box3(32767, 32767, 32767)));
    chk(up_hi == box3(-32768, -32768, -32768), "R1", "up_hi", 128'(up_hi), 128'(box3(-32768, -32768, -32768)));

    // X axis, split 0 (R3, R4, R5 with boundaries)
    cfg(0, 0, 1'b1);
    send(8'd1, box3(-50, 0, 0), box3(-10, 5, 5));
    send(8'd2, box3(10, 1, 1), box3(40, 2, 2));
    send(8'd3, box3(-5, -7, 3), box3(5, 9, 4));
    send(8'd4, box3(-20, 0, 0), box3(0, 0, 0));     // R3 high equals split
    send(8'd5, box3(0, 0, 0), box3(9, 0, 0));       // R4 low equals split
    wait_drain();
    check_up("R8");
    check_up("R10");

    // R2: level 1 selects Y
    cfg(100, 1, 1'b1);
    send(8'd6, box3(500, 0, 0), box3(600, 100, 0));
    send(8'd7, box3(-500, 150, 0), box3(-400, 200, 0));
    send(8'd8, box3(0, 50, 0), box3(0, 150, 0));
    wait_drain();
    // R2: level 5 selects Z
    cfg(-20, 5, 1'b1);
    send(8'd9, box3(0, 0, -30), box3(0, 0, -25));
    send(8'd10, box3(-99, 0, -25), box3(99, 0, -10));
    wait_drain();
    check_up("R2");

    // R12 signed compare: X in [-50,20], split -100 must go right
    cfg(-100, 0, 1'b1);
    send(8'd11, box3(-50, 0, 0), box3(20, 0, 0));
    wait_drain();
    check_up("R12");

    // R6 stall, then R11 write while busy
    @(negedge clk); l_ready = 1'b0;
    send(8'd12, box3(-300, 0, 0), box3(-200, 0, 0));
    repeat (3) @(negedge clk);
    #1;
    chk(l_valid == 1'b1, "R6", "left held valid", 128'(l_valid), 128'(1));
    cfg(500, 0, 1'b0);
    @(negedge clk); l_ready = 1'b1;
    wait_drain();
    send(8'd13, box3(10, 0, 0), box3(50, 0, 0));   // still right: split stays -100 (R11)
    wait_drain();
    cfg(500, 0, 1'b1);
    send(8'd14, box3(10, 0, 0), box3(50, 0, 0));   // now left (R11)
    wait_drain();
    check_up("R11");

    // R9 child reports overwrite subtree state
    upd(0, 40, box3(-1000, -1000, -1000), box3(1000, 1000, 1000));
    check_up("R9");
    upd(1, 3, box3(7, 7, 7), box3(8, 8, 8));
    check_up("R9");
    send(8'd15, box3(600, 0, 0), box3(700, 0, 0));  // right, adds on top of report
    wait_drain();
    check_up("R9");

    // R7 keep store fills to 16
    cfg(0, 0, 1'b1);
    @(negedge clk); k_ready = 1'b0;
    for (int i = 0; i < 16; i++) send(8'(32 + i), box3(-i - 1, 0, 0), box3(i + 1, 0, 0));
    check_up("R7");
    @(negedge clk);
    in_id = 8'd99; in_lo = box3(-3, 0, 0); in_hi = box3(3, 0, 0); in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(in_ready == 1'b0, "R7", "ready while full", 128'(in_ready), 128'(0));
      @(negedge clk);
    end
    k_ready = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    q_k.push_back('{id: 8'd99, lo: box3(-3, 0, 0), hi: box3(3, 0, 0)});
    model_add(2, box3(-3, 0, 0), box3(3, 0, 0));
    @(negedge clk); in_valid = 1'b0;
    wait_drain();
    chk(q_k.size() == 0, "R7", "kept objects drained", 128'(q_k.size()), 128'(0));
    check_up("R8");

    finish_run();
  end
endmodule